// File: doc/BRIEF.md
# Interrupt Acknowledge Vector Generator

This block drives the data bus of an interrupt controller while the processor runs its interrupt-acknowledge cycles. It is given the level that won priority resolution (0 to 7), the programmed upper address bits, a routine-spacing select and a protocol select. From these it produces the bytes the processor reads on each low pulse of the active-low acknowledge strobe.

In call-instruction mode the block returns three bytes, one per acknowledge pulse. The first is a call opcode, the second is the low byte of a 16-bit routine address and the third is its high byte. The level fills low address bits, at a spacing of 4 or 8 bytes per routine. In byte-vector mode every acknowledge pulse returns one vector byte. Its upper five bits come from the programmed base and its lower three bits hold the level.

When several controllers are cascaded, the block decides for each byte whether this device drives the bus. A master always drives the opcode byte. It leaves the address bytes, or the vector byte, to a slave when the winning level has a slave attached. A slave drives those bytes only when the cascade lines select it.

Top module: `intack_vector_gen`

## Requirements
- R1: After reset the byte position is the first byte of a sequence, and with `ack_n` high `doe` is 0 and `dout` is 8'h00. A reset in the middle of a sequence makes the next pulse return the first byte again.
- R2: In call mode (`byte_mode`=0) the first byte of the sequence is the opcode 8'hCD.
- R3: In call mode with `spacing4`=1 the second byte is {base_addr[7:5], level[2:0], 2'b00}.
- R4: In call mode with `spacing4`=0 the second byte is {base_addr[7:6], level[2:0], 3'b000}, and base_addr[5] has no effect.
- R5: In call mode the third byte is base_addr[15:8].
- R6: In byte-vector mode (`byte_mode`=1) the byte is {base_addr[15:11], level[2:0]}. Neither `spacing4` nor base_addr[10:5] affects it.
- R7: The byte position advances one step at each rising edge of `ack_n`. In call mode it returns to the first byte after the third. In byte-vector mode it stays on the single vector byte, so every pulse returns that byte.
- R8: `doe` is 1 only while `ack_n` is low and this device owns the current byte. `dout` is 8'h00 whenever `doe` is 0.
- R9: With `casc_en`=1 and `is_master`=1, the device owns the call opcode byte. It owns the address bytes and the vector byte only when `level_has_slave`=0.
- R10: With `casc_en`=1 and `is_master`=0, the device never owns the call opcode byte. It owns the address bytes and the vector byte only when `cas_match`=1.
- R11: With `casc_en`=0 the device owns every byte of both protocols.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ack_n | input | 1 | Active-low interrupt-acknowledge strobe |
| level | input | 3 | Resolved interrupt level |
| base_addr | input | 11 | Programmed address bits 15..5 |
| spacing4 | input | 1 | 1 selects 4-byte routine spacing, 0 selects 8-byte spacing |
| byte_mode | input | 1 | 1 selects byte-vector protocol, 0 selects call protocol |
| casc_en | input | 1 | 1 when controllers are cascaded |
| is_master | input | 1 | 1 when this device is the cascade master |
| level_has_slave | input | 1 | Master only: a slave is attached to the winning level |
| cas_match | input | 1 | Slave only: the cascade lines carry this device's identity |
| dout | output | 8 | Data bus byte |
| doe | output | 1 | Data bus output enable |

## Verification
The hardest case to reach from the ports is a cascaded call sequence in which ownership moves from one device to the other partway through. The master must release the bus after the opcode, and the slave must stay silent on the opcode and then drive the address bytes. The bench sets the cascade inputs for each role and walks full three-pulse sequences. At every pulse it checks both the enable and the bus value, and it checks the enable again while the strobe is high between pulses. A reset issued after one pulse covers the restart of a sequence from the middle.

// File: rtl/intack_vector_gen.sv
module intack_vector_gen #(
  parameter logic [7:0] CALL_OPCODE = 8'hCD,
  parameter int         SEQ_LEN     = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ack_n,
  input  logic [2:0]  level,
  input  logic [15:5] base_addr,
  input  logic        spacing4,
  input  logic        byte_mode,
  input  logic        casc_en,
  input  logic        is_master,
  input  logic        level_has_slave,
  input  logic        cas_match,
  output logic [7:0]  dout,
  output logic        doe
);
  localparam int               IDX_W = $clog2(SEQ_LEN);
  localparam logic [IDX_W-1:0] LAST  = IDX_W'(SEQ_LEN - 1);

  logic             ack_q;
  logic [IDX_W-1:0] idx;
  logic             rise;
  logic             own;
  logic [7:0]       lo_byte, vec_byte, cur_byte;

  assign rise = ack_n & ~ack_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack_q <= 1'b1;
      idx   <= '0;
    end else begin
      ack_q <= ack_n;
      if (rise)
        idx <= (byte_mode || idx == LAST) ? '0 : idx + 1'b1;
    end
  end

  assign lo_byte  = spacing4 ? {base_addr[7:5], level, 2'b00}
                             : {base_addr[7:6], level, 3'b000};
  assign vec_byte = {base_addr[15:11], level};

  always_comb begin
    if (byte_mode)       cur_byte = vec_byte;
    else if (idx == '0)  cur_byte = CALL_OPCODE;
    else if (idx == 1)   cur_byte = lo_byte;
    else                 cur_byte = base_addr[15:8];
  end

  always_comb begin
    if (!casc_en)       own = 1'b1;
    else if (is_master) own = (!byte_mode && idx == '0) || !level_has_slave;
    else                own = cas_match && (byte_mode || idx != '0);
  end

  assign doe  = !ack_n && own;
  assign dout = doe ? cur_byte : 8'h00;

  AST_OE_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n) doe |-> !ack_n); // R8
  AST_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !doe |-> dout == 8'h00); // R8
  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n) idx <= LAST); // R7
  AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !rise |=> $stable(idx)); // R7
  AST_VECTOR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) (rise && byte_mode) |=> idx == '0); // R7
  AST_SLAVE_NO_OPCODE: assert property (@(posedge clk) disable iff (!rst_n)
    (casc_en && !is_master && !byte_mode && idx == '0) |-> !doe); // R10
  AST_OPCODE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (doe && !byte_mode && idx == '0) |-> dout == CALL_OPCODE); // R2
  AST_STANDALONE_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    (!casc_en && !ack_n) |-> doe); // R11
endmodule

// File: tb/sim_intack_vector_gen.sv
module sim_intack_vector_gen;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0, ack_n = 1;
  logic [2:0]  level = 0;
  logic [15:0] base16 = 0;
  logic        spacing4 = 0, byte_mode = 0, casc_en = 0, is_master = 0;
  logic        level_has_slave = 0, cas_match = 0;
  logic [7:0]  dout;
  logic        doe;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  intack_vector_gen u0 (
    .clk(clk), .rst_n(rst_n), .ack_n(ack_n), .level(level),
    .base_addr(base16[15:5]), .spacing4(spacing4), .byte_mode(byte_mode),
    .casc_en(casc_en), .is_master(is_master), .level_has_slave(level_has_slave),
    .cas_match(cas_match), .dout(dout), .doe(doe));

  // {byte_mode, spacing4, level, base16, byte0, byte1, byte2}
  localparam logic [44:0] TBL [8] = '{
    {1'b0, 1'b1, 3'd5, 16'hABE0, 8'hCD, 8'hF4, 8'hAB},
    {1'b0, 1'b0, 3'd3, 16'h12E0, 8'hCD, 8'hD8, 8'h12},
    {1'b0, 1'b1, 3'd0, 16'h0000, 8'hCD, 8'h00, 8'h00},
    {1'b0, 1'b0, 3'd7, 16'hFFC0, 8'hCD, 8'hF8, 8'hFF},
    {1'b0, 1'b1, 3'd7, 16'h3420, 8'hCD, 8'h3C, 8'h34},
    {1'b1, 1'b1, 3'd6, 16'hF800, 8'hFE, 8'h00, 8'h00},
    {1'b1, 1'b0, 3'd6, 16'hFFE0, 8'hFE, 8'h00, 8'h00},
    {1'b1, 1'b1, 3'd1, 16'h5000, 8'h51, 8'h00, 8'h00}
  };

  task automatic check(string req, logic [8:0] act, logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual doe/dout=%h expected %h", req, act, exp);
    end
  endtask

  // one acknowledge pulse: check bus while low, then idle bus once high
  task automatic pulse(string req, logic eoe, logic [7:0] edata);
    @(negedge clk) ack_n = 0;
    #1 check(req, {doe, dout}, {eoe, eoe ? edata : 8'h00});
    @(negedge clk) ack_n = 1;
    #1 check({req, " R8 idle"}, {doe, dout}, 9'h000);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 check("R1 reset", {doe, dout}, 9'h000);
    rst_n = 1;
    @(negedge clk);
    #1 check("R1 after reset", {doe, dout}, 9'h000);

    // R11 standalone: R2..R7 data per table
    for (int i = 0; i < 8; i++) begin
      byte_mode = TBL[i][44];
      spacing4  = TBL[i][43];
      level     = TBL[i][42:40];
      base16    = TBL[i][39:24];
      if (byte_mode) begin
        pulse("R6 vector", 1'b1, TBL[i][23:16]);
        pulse("R7 vector repeats", 1'b1, TBL[i][23:16]);
      end else begin
        pulse("R2 opcode", 1'b1, TBL[i][23:16]);
        pulse(spacing4 ? "R3 low byte" : "R4 low byte", 1'b1, TBL[i][15:8]);
        pulse("R5 high byte", 1'b1, TBL[i][7:0]);
      end
    end

    // R7 wrap: next call sequence starts at opcode
    byte_mode = 0; spacing4 = 1; level = 2; base16 = 16'h8060;
    pulse("R7 wrap opcode", 1'b1, 8'hCD);
    // R1 reset mid-sequence
    @(negedge clk) rst_n = 0;
    @(negedge clk) rst_n = 1;
    pulse("R1 restart opcode", 1'b1, 8'hCD);
    pulse("R3 low byte lvl2", 1'b1, 8'h68);
    pulse("R5 high byte", 1'b1, 8'h80);

    // R9 master with slave on level
    casc_en = 1; is_master = 1; level_has_slave = 1;
    pulse("R9 master opcode", 1'b1, 8'hCD);
    pulse("R9 master releases low", 1'b0, 8'h00);
    pulse("R9 master releases high", 1'b0, 8'h00);
    // R9 master, no slave on level
    level_has_slave = 0;
    pulse("R9 master opcode", 1'b1, 8'hCD);
    pulse("R9 master low", 1'b1, 8'h68);
    pulse("R9 master high", 1'b1, 8'h80);
    byte_mode = 1; level_has_slave = 1;
    pulse("R9 master vector released", 1'b0, 8'h00);
    level_has_slave = 0;
    pulse("R9 master vector own", 1'b1, 8'h82);

    // R10 slave
    byte_mode = 0; is_master = 0; cas_match = 1;
    pulse("R10 slave no opcode", 1'b0, 8'h00);
    pulse("R10 slave low", 1'b1, 8'h68);
    pulse("R10 slave high", 1'b1, 8'h80);
    cas_match = 0;
    pulse("R10 unselected opcode", 1'b0, 8'h00);
    pulse("R10 unselected low", 1'b0, 8'h00);
    pulse("R10 unselected high", 1'b0, 8'h00);
    byte_mode = 1;
    pulse("R10 unselected vector", 1'b0, 8'h00);
    cas_match = 1;
    pulse("R10 slave vector", 1'b1, 8'h82);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule